// File: doc/BRIEF.md
# Trigger-Committed Fractional Clock Divider with Parent Select

This block derives a peripheral clock enable from one of several parent clocks. Each parent arrives as a one-cycle enable strobe in the block's single clock domain. A fixed-point divider rescales the selected parent's strobes, and the result leaves the block as a registered pulse train, `clk_en_out`.

Software programs the parent code and the divider value into a staging register. It writes that register with a bit mask, so the bits outside the mask keep their values. Nothing staged takes effect on the write. A request strobe captures the staged value and marks the channel busy. The captured setting becomes active at the next output pulse, where the phase accumulator restarts from zero, and the busy flag then clears. When the pre-trigger variant is built (`HAS_PRE = 1`), the selector is committed by its own pre-trigger and the main trigger commits only the divider. A request made while the clock gate is shut, or one that carries an invalid parent code, is refused and raises a sticky error.

Top module: `fracdiv_clkgen`

## Requirements
- R1: The divider field `d` (bits [DIV_W-1:0] of the staging register, with FRAC_W fractional bits) selects a divisor of (d + 2^FRAC_W) / 2^FRAC_W. After a committed switch, n ticks of the selected parent produce exactly floor(n·2^FRAC_W / (d + 2^FRAC_W)) pulses on `clk_en_out`. A field of 0 passes every tick.
- R2: A divider field of all ones gives the largest divisor, (2^DIV_W − 1 + 2^FRAC_W) / 2^FRAC_W, and still obeys the count rule of R1.
- R3: A write to the staging register leaves `act_div` and `act_idx` unchanged until a trigger commits it.
- R4: After an accepted trigger, the busy output of that channel reads 1 until the switch is applied and then reads 0. In the cycle after it clears, `act_div` and `act_idx` show the captured values.
- R5: The parent code sits in bits [DIV_W+SEL_W-1:DIV_W]. A code is valid only when it is odd and code>>1 < NPAR, and it then selects parent index code>>1. A trigger that carries an invalid code sets `trig_err`, does not go busy, and changes nothing.
- R6: With `HAS_PRE = 1`, `pre_go` commits only the parent selection and `trig_go` commits only the divider. With `HAS_PRE = 0`, either strobe commits both.
- R7: A staging write replaces only the bits set in `st_wmask`. Every other bit of `st_rdata` keeps its previous value.
- R8: A trigger raised while `gate_open` is 0 sets `trig_err`, leaves the channel idle, and applies nothing. If the gate closes while a switch is pending, the request is cancelled, busy drops in the next cycle, and `trig_err` is set.
- R9: While `gate_open` is 0, `clk_en_out` stays 0.
- R10: The switch takes place only on a cycle that emits an output pulse under the old setting. The accumulator restarts at zero at that point, so the first pulse under the new setting is never shortened.
- R11: `trig_err` stays set until a later trigger is accepted, and the acceptance clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_tick | input | NPAR | One-cycle enable strobes, one per parent |
| gate_open | input | 1 | Clock gate open (1) or shut (0) |
| st_we | input | 1 | Staging register write strobe |
| st_wmask | input | REG_W | Bits to replace on write |
| st_wdata | input | REG_W | Write data |
| trig_go | input | 1 | Main trigger request |
| pre_go | input | 1 | Pre-trigger request (selector) |
| st_rdata | output | REG_W | Staging register contents |
| trig_busy | output | 1 | Main trigger pending |
| pre_busy | output | 1 | Pre-trigger pending |
| act_div | output | DIV_W | Active divider field |
| act_idx | output | log2(NPAR) | Active parent index |
| trig_err | output | 1 | Sticky refused or cancelled request |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
A corrupted accumulator or divisor shows up as a wrong pulse count over a window of known parent ticks. Because the bench counts from a clean restart, the count is already off within one divisor period of the switch. A stuck or early-cleared commit state appears on the busy outputs at the very next cycle edge, or as `act_div` and `act_idx` changing before or without a trigger. A selector decode fault appears as the error flag failing to rise in the cycle after a bad code is triggered, or as the pulse rate following the wrong parent.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
  // Commit channel state: idle, or holding a captured setting until the next pulse boundary
  typedef enum logic {
    CM_IDLE = 1'b0,
    CM_WAIT = 1'b1
  } cm_state_t;
endpackage

// File: rtl/fracdiv_stage_reg.sv
module fracdiv_stage_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wmask,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] q_d;

  // Field replacement: masked bits take new data, the rest keep their value
  always_comb begin
    q_d = (q & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/fracdiv_commit.sv
module fracdiv_commit
  import fracdiv_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          gate_open,
  input  logic          boundary,
  input  logic          bad,
  input  logic [PW-1:0] pay_in,
  output logic          busy,
  output logic          apply,
  output logic          accepted,
  output logic          err_set,
  output logic [PW-1:0] pay_q
);
  cm_state_t st_q;
  cm_state_t st_d;

  always_comb begin
    st_d     = st_q;
    apply    = 1'b0;
    accepted = 1'b0;
    err_set  = 1'b0;
    case (st_q)
      CM_IDLE: begin
        if (go) begin
          if (gate_open && !bad) begin
            accepted = 1'b1;
            st_d     = CM_WAIT;
          end else begin
            err_set = 1'b1;
          end
        end
      end
      CM_WAIT: begin
        if (!gate_open) begin
          err_set = 1'b1;
          st_d    = CM_IDLE;
        end else if (boundary) begin
          apply = 1'b1;
          st_d  = CM_IDLE;
        end
      end
      default: st_d = CM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CM_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // Setting captured at acceptance so later staging writes cannot disturb it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '0;
    end else if (accepted) begin
      pay_q <= pay_in;
    end
  end

  assign busy = (st_q == CM_WAIT);
endmodule

// File: rtl/fracdiv_core.sv
module fracdiv_core #(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_field,
  output logic             fire,
  output logic             en_q
);
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] divisor;
  logic [ACC_W-1:0] sum;
  logic             step;

  always_comb begin
    divisor = {2'b00, div_field} + ONE;
    step    = tick & run;
    sum     = acc_q + ONE;
    fire    = step && (sum >= divisor);
    acc_d   = acc_q;
    if (restart) begin
      acc_d = '0;
    end else if (step) begin
      acc_d = fire ? (sum - divisor) : sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      en_q  <= fire;
    end
  end
endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen #(
  parameter int NPAR    = 4,
  parameter int SEL_W   = 3,
  parameter int DIV_W   = 8,
  parameter int FRAC_W  = 3,
  parameter int REG_W   = 16,
  parameter bit HAS_PRE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPAR-1:0]         par_tick,
  input  logic                    gate_open,
  input  logic                    st_we,
  input  logic [REG_W-1:0]        st_wmask,
  input  logic [REG_W-1:0]        st_wdata,
  input  logic                    trig_go,
  input  logic                    pre_go,
  output logic [REG_W-1:0]        st_rdata,
  output logic                    trig_busy,
  output logic                    pre_busy,
  output logic [DIV_W-1:0]        act_div,
  output logic [$clog2(NPAR)-1:0] act_idx,
  output logic                    trig_err,
  output logic                    clk_en_out
);
  localparam int IDX_W   = $clog2(NPAR);
  localparam int SEL_LSB = DIV_W;
  localparam logic [SEL_W-1:0] NPAR_L = SEL_W'(NPAR);

  logic [REG_W-1:0] stage_q;
  logic [DIV_W-1:0] st_div;
  logic [SEL_W-1:0] st_sel;
  logic [IDX_W-1:0] st_idx;
  logic             sel_ok;

  logic             div_busy, div_apply, div_acc, div_err;
  logic [DIV_W-1:0] div_pay;
  logic             sel_busy, sel_apply, sel_acc, sel_err;
  logic [IDX_W-1:0] sel_pay;

  logic [DIV_W-1:0] act_div_q;
  logic [IDX_W-1:0] act_idx_q;
  logic             err_q, err_d;
  logic             fire;
  logic             sel_tick;

  fracdiv_stage_reg #(.REG_W(REG_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .wmask (st_wmask),
    .wdata (st_wdata),
    .q     (stage_q)
  );

  // Selector decode: odd codes name parent code>>1
  always_comb begin
    st_div = stage_q[DIV_W-1:0];
    st_sel = stage_q[SEL_LSB +: SEL_W];
    st_idx = st_sel[1 +: IDX_W];
    sel_ok = st_sel[0] && ({1'b0, st_sel[SEL_W-1:1]} < NPAR_L);
  end

  generate
    if (HAS_PRE) begin : g_pre
      fracdiv_commit #(.PW(DIV_W)) u_div_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (trig_go),
        .gate_open (gate_open),
        .boundary  (fire),
        .bad       (1'b0),
        .pay_in    (st_div),
        .busy      (div_busy),
        .apply     (div_apply),
        .accepted  (div_acc),
        .err_set   (div_err),
        .pay_q     (div_pay)
      );
      fracdiv_commit #(.PW(IDX_W)) u_sel_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (pre_go),
        .gate_open (gate_open),
        .boundary  (fire),
        .bad       (~sel_ok),
        .pay_in    (st_idx),
        .busy      (sel_busy),
        .apply     (sel_apply),
        .accepted  (sel_acc),
        .err_set   (sel_err),
        .pay_q     (sel_pay)
      );
    end else begin : g_joint
      logic [DIV_W+IDX_W-1:0] joint_pay;
      fracdiv_commit #(.PW(DIV_W+IDX_W)) u_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (trig_go | pre_go),
        .gate_open (gate_open),
        .boundary  (fire),
        .bad       (~sel_ok),
        .pay_in    ({st_idx, st_div}),
        .busy      (div_busy),
        .apply     (div_apply),
        .accepted  (div_acc),
        .err_set   (div_err),
        .pay_q     (joint_pay)
      );
      assign div_pay   = joint_pay[DIV_W-1:0];
      assign sel_pay   = joint_pay[DIV_W +: IDX_W];
      assign sel_busy  = div_busy;
      assign sel_apply = div_apply;
      assign sel_acc   = 1'b0;
      assign sel_err   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div_q <= '0;
    end else if (div_apply) begin
      act_div_q <= div_pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_idx_q <= '0;
    end else if (sel_apply) begin
      act_idx_q <= sel_pay;
    end
  end

  // Error flag: set wins over clear
  always_comb begin
    err_d = err_q;
    if (div_err || sel_err) begin
      err_d = 1'b1;
    end else if (div_acc || sel_acc) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign sel_tick = par_tick[act_idx_q];

  fracdiv_core #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sel_tick),
    .run       (gate_open),
    .restart   (div_apply | sel_apply),
    .div_field (act_div_q),
    .fire      (fire),
    .en_q      (clk_en_out)
  );

  assign st_rdata  = stage_q;
  assign trig_busy = div_busy;
  assign pre_busy  = sel_busy;
  assign act_div   = act_div_q;
  assign act_idx   = act_idx_q;
  assign trig_err  = err_q;
endmodule

// File: rtl/fracdiv_clkgen_chk.sv
module fracdiv_clkgen_chk #(
  parameter int NPAR  = 4,
  parameter int DIV_W = 8,
  parameter int REG_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPAR-1:0]         par_tick,
  input logic                    gate_open,
  input logic                    st_we,
  input logic [REG_W-1:0]        st_wmask,
  input logic                    trig_go,
  input logic [REG_W-1:0]        st_rdata,
  input logic                    trig_busy,
  input logic                    pre_busy,
  input logic [DIV_W-1:0]        act_div,
  input logic [$clog2(NPAR)-1:0] act_idx,
  input logic                    trig_err,
  input logic                    clk_en_out
);
  // R9: a shut gate suppresses the next output pulse
  p_no_pulse_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> !clk_en_out);

  // R8: a pending switch is cancelled with an error when the gate shuts
  p_gate_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_busy && !gate_open) |=> (!trig_busy && trig_err));

  // R8: a trigger against a shut gate is refused
  p_reject_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_go && !trig_busy && !gate_open) |=> (!trig_busy && trig_err));

  // R3: the active divider only moves out of a pending commit
  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_busy |=> $stable(act_div));

  // R6: the active parent only moves out of a pending selector commit
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_busy |=> $stable(act_idx));

  // R7: unmasked bits survive a staging write
  p_preserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> ((st_rdata & ~$past(st_wmask)) == ($past(st_rdata) & ~$past(st_wmask))));

  // R1: every output pulse follows a parent tick
  p_pulse_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(|par_tick));
endmodule

bind fracdiv_clkgen fracdiv_clkgen_chk #(.NPAR(NPAR), .DIV_W(DIV_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_tick   (par_tick),
  .gate_open  (gate_open),
  .st_we      (st_we),
  .st_wmask   (st_wmask),
  .trig_go    (trig_go),
  .st_rdata   (st_rdata),
  .trig_busy  (trig_busy),
  .pre_busy   (pre_busy),
  .act_div    (act_div),
  .act_idx    (act_idx),
  .trig_err   (trig_err),
  .clk_en_out (clk_en_out)
);

// File: tb/fracdiv_clkgen_bench.sv
`timescale 1ns/1ps
module fracdiv_clkgen_bench;
  localparam int NPAR = 4;
  localparam int DIV_W = 8;
  localparam int FRAC_W = 3;
  localparam int REG_W = 16;
  localparam logic [REG_W-1:0] FIELD_MASK = 16'h07FF;
  localparam logic [REG_W-1:0] SPARE_MASK = 16'hF800;

  // Vector: [26:24] parent code, [23:16] divider field, [15:0] window cycles
  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{
    {5'd0, 3'd1, 8'd0,   16'd40},
    {5'd0, 3'd3, 8'd4,   16'd60},
    {5'd0, 3'd5, 8'd255, 16'd300},
    {5'd0, 3'd7, 8'd13,  16'd200},
    {5'd0, 3'd1, 8'd8,   16'd50}
  };

  logic             clk;
  logic             rst_n;
  logic [NPAR-1:0]  par_tick;
  logic             gate_open;
  logic             st_we;
  logic [REG_W-1:0] st_wmask;
  logic [REG_W-1:0] st_wdata;
  logic             trig_go;
  logic             pre_go;
  logic [REG_W-1:0] st_rdata;
  logic             trig_busy;
  logic             pre_busy;
  logic [DIV_W-1:0] act_div;
  logic [1:0]       act_idx;
  logic             trig_err;
  logic             clk_en_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit tick_on = 1'b1;
  bit done = 1'b0;

  fracdiv_clkgen u_fracdiv_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_tick   (par_tick),
    .gate_open  (gate_open),
    .st_we      (st_we),
    .st_wmask   (st_wmask),
    .st_wdata   (st_wdata),
    .trig_go    (trig_go),
    .pre_go     (pre_go),
    .st_rdata   (st_rdata),
    .trig_busy  (trig_busy),
    .pre_busy   (pre_busy),
    .act_div    (act_div),
    .act_idx    (act_idx),
    .trig_err   (trig_err),
    .clk_en_out (clk_en_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of parent strobes: parent i ticks every (i+1) cycles
  task automatic drive();
    cyc++;
    for (int i = 0; i < NPAR; i++) begin
      par_tick[i] = tick_on && ((cyc % (i + 1)) == 0);
    end
  endtask

  task automatic step();
    drive();
    @(negedge clk);
  endtask

  task automatic stage_write(input logic [REG_W-1:0] mask, input logic [REG_W-1:0] data);
    st_we = 1'b1; st_wmask = mask; st_wdata = data;
    step();
    st_we = 1'b0; st_wmask = '0; st_wdata = '0;
  endtask

  // Issue the selected strobes and wait for both channels to go idle
  task automatic commit_wait(input bit use_main, input bit use_pre, output bit saw_busy);
    int guard;
    guard = 0;
    trig_go = use_main; pre_go = use_pre;
    step();
    trig_go = 1'b0; pre_go = 1'b0;
    saw_busy = trig_busy || pre_busy;
    while ((trig_busy || pre_busy) && guard < 4000) begin
      step();
      guard++;
    end
  endtask

  // Count selected-parent ticks and output pulses over n cycles after a switch
  task automatic window(input int n, input int idx, output int ticks, output int pulses);
    ticks = 0; pulses = 0;
    for (int k = 0; k < n; k++) begin
      drive();
      if (par_tick[idx]) ticks++;
      @(negedge clk);
      if (clk_en_out) pulses++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit saw;
    int ticks, pulses, exp_p;
    logic [2:0] code;
    logic [7:0] dv;
    int ncyc;
    rst_n = 1'b0; par_tick = '0; gate_open = 1'b1;
    st_we = 1'b0; st_wmask = '0; st_wdata = '0;
    trig_go = 1'b0; pre_go = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R4 reset busy", int'(trig_busy), 0);
    chk("R6 reset pre_busy", int'(pre_busy), 0);
    chk("R11 reset err", int'(trig_err), 0);
    chk("R7 reset rdata", int'(st_rdata), 0);
    chk("R3 reset act_div", int'(act_div), 0);
    chk("R9 reset clk_en_out", int'(clk_en_out), 0);

    // Spare bits written once, must survive every later field write (R7)
    stage_write(SPARE_MASK, 16'hA800);
    chk("R7 spare write", int'(st_rdata), 16'hA800);

    for (int v = 0; v < NV; v++) begin
      code = VEC[v][26:24];
      dv   = VEC[v][23:16];
      ncyc = int'(VEC[v][15:0]);
      stage_write(FIELD_MASK, {5'b11111, code, dv});
      chk("R7 spare preserved", int'(st_rdata[15:11]), 5'b10101);
      if (v > 0) chk("R3 staged not active", int'(act_div), int'(VEC[v-1][23:16]));
      commit_wait(1'b1, 1'b1, saw);
      chk("R4 busy seen", int'(saw), 1);
      chk("R4 act_div applied", int'(act_div), int'(dv));
      chk("R5 act_idx decoded", int'(act_idx), int'(code) >> 1);
      window(ncyc, int'(code) >> 1, ticks, pulses);
      exp_p = (ticks * (1 << FRAC_W)) / (int'(dv) + (1 << FRAC_W));
      if (dv == 8'hFF) chk("R2 max divisor pulses", pulses, exp_p);
      else chk("R1 R10 pulse count", pulses, exp_p);
    end

    // R8: trigger with the gate shut is refused; R9: no pulses while shut
    gate_open = 1'b0;
    stage_write(FIELD_MASK, {5'b0, 3'd1, 8'd3});
    trig_go = 1'b1; pre_go = 1'b1;
    step();
    trig_go = 1'b0; pre_go = 1'b0;
    chk("R8 refused busy", int'(trig_busy | pre_busy), 0);
    chk("R8 refused err", int'(trig_err), 1);
    chk("R8 nothing applied", int'(act_div), 8);
    window(20, 0, ticks, pulses);
    chk("R9 gated pulses", pulses, 0);
    chk("R11 err sticky", int'(trig_err), 1);

    // R11: an accepted trigger clears the error
    gate_open = 1'b1;
    commit_wait(1'b1, 1'b1, saw);
    chk("R11 err cleared", int'(trig_err), 0);
    chk("R4 act_div after reopen", int'(act_div), 3);

    // R5: even code is invalid on the selector channel
    stage_write(FIELD_MASK, {5'b0, 3'd2, 8'd3});
    pre_go = 1'b1;
    step();
    pre_go = 1'b0;
    chk("R5 invalid err", int'(trig_err), 1);
    chk("R5 invalid not busy", int'(pre_busy), 0);
    chk("R5 act_idx kept", int'(act_idx), 0);

    // R6: pre-trigger moves only the parent, main trigger only the divider
    stage_write(FIELD_MASK, {5'b0, 3'd3, 8'd20});
    commit_wait(1'b0, 1'b1, saw);
    chk("R6 pre idx", int'(act_idx), 1);
    chk("R6 pre leaves div", int'(act_div), 3);
    commit_wait(1'b1, 1'b0, saw);
    chk("R6 main div", int'(act_div), 20);
    chk("R6 main leaves idx", int'(act_idx), 1);

    // R8: gate shut while a switch is pending cancels it
    tick_on = 1'b0;
    stage_write(FIELD_MASK, {5'b0, 3'd3, 8'd7});
    trig_go = 1'b1;
    step();
    trig_go = 1'b0;
    chk("R4 pending busy", int'(trig_busy), 1);
    repeat (3) step();
    chk("R4 busy holds without boundary", int'(trig_busy), 1);
    gate_open = 1'b0;
    step();
    chk("R8 abort busy", int'(trig_busy), 0);
    chk("R8 abort err", int'(trig_err), 1);
    chk("R8 abort keeps div", int'(act_div), 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule